// File: doc/BRIEF.md
# Dual-Precision Signed Multiplier

This block multiplies a signed 16-bit multiplicand by a signed 8-bit operand and returns a registered 24-bit two's-complement product with a valid flag. A per-transfer precision flag picks one of two modes. Full mode uses the whole 8-bit operand. Reduced mode uses only the operand's upper four bits. In reduced mode the product keeps the full-mode scale, as if the four dropped low bits were zero. A configuration controller elsewhere in the adaptive datapath drives the precision flag. It can run reduced precision while coefficients are still coarse and switch to full precision later. Operands are accepted on any cycle that has `in_valid` high. The product appears two clock edges later.

A parameter selects how the block is built. The masking build has one full-width multiplier and forces the unused low operand bits to zero in reduced mode. The split build has two units: a 16×8 array and a small 16×4 shift-add unit. Each unit has its own operand registers, and only the selected unit's registers load. The other unit's inputs stay frozen, so it does no switching. Operand registers also hold during idle cycles.

Top module: `dpmul_top`

## Requirements
- R1: While reset is high and on the first cycle after it falls, `out_valid` is 0, `out_prod` is 0 and `out_full` is 0.
- R2: A transfer with `prec_full`=1 yields `out_prod` equal to the signed product of `a_in` and `b_in`, sign-extended to 24 bits. This includes -32768 × -128 = 4194304.
- R3: A transfer with `prec_full`=0 yields the signed product of `a_in` and `b_in` with bits [3:0] of `b_in` replaced by zero, so `out_prod[3:0]` is always 0 in this mode. In the split build, the full-width unit's operand registers do not change during such a transfer.
- R4: `out_valid` is high exactly two rising edges after a cycle with `in_valid` high, and low otherwise.
- R5: `prec_full` is sampled together with its own operand pair. `out_full` reports the mode of the product currently presented. Changing the flag between back-to-back transfers alters neither product. In the split build, a full-precision transfer leaves the reduced unit's operand registers unchanged.
- R6: When `out_valid` is low, `out_prod` and `out_full` keep the values of the last valid product.
- R7: The masking build and the split build give identical `out_valid`, `out_full` and `out_prod` for identical stimulus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair and precision flag are present |
| prec_full | input | 1 | 1 = full 16×8 product, 0 = reduced 16×4 product |
| a_in | input | 16 | Signed multiplicand |
| b_in | input | 8 | Signed multiplier operand |
| out_valid | output | 1 | `out_prod` holds a new product |
| out_full | output | 1 | Mode with which the presented product was computed |
| out_prod | output | 24 | Signed product, full-mode scale |

## Verification
The hardest case to reach from the ports is a precision switch while a product of the other mode is still in flight. In the split build, this is the point where one unit's frozen operands must still produce the older product while the other unit's registers load the newer pair. The stimulus streams transfers back to back and flips the precision flag on a pattern that does not line up with the operand sweep. Every pairing of old and new mode therefore occurs with no idle cycle between them. Periodic idle cycles are inserted on a separate pattern, so held outputs are also seen after both modes.

// File: rtl/dpmul_pkg.sv
package dpmul_pkg;

    localparam int unsigned DPM_A_W   = 16;
    localparam int unsigned DPM_B_W   = 8;
    localparam int unsigned DPM_RED_W = 4;

    typedef enum logic {
        PREC_RED  = 1'b0,
        PREC_FULL = 1'b1
    } prec_e;

    typedef enum logic {
        BUILD_MASK  = 1'b0,
        BUILD_SPLIT = 1'b1
    } build_e;

    // Product width for the given operand widths.
    function automatic int unsigned prod_width(input int unsigned aw, input int unsigned bw);
        return aw + bw;
    endfunction

    // Left shift that restores full-mode scale for a reduced product.
    function automatic int unsigned red_shift(input int unsigned bw, input int unsigned rw);
        return bw - rw;
    endfunction

endpackage

// File: rtl/dpmul_isol.sv
// Operand stage: registers the accepted pair into the operand registers of
// the unit chosen by the build and the precision flag; others stay frozen.
module dpmul_isol
    import dpmul_pkg::*;
#(
    parameter build_e      BUILD = BUILD_MASK,
    parameter int unsigned A_W   = DPM_A_W,
    parameter int unsigned B_W   = DPM_B_W,
    parameter int unsigned RED_W = DPM_RED_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             prec_full,
    input  logic [A_W-1:0]   a_in,
    input  logic [B_W-1:0]   b_in,
    output logic             s1_valid,
    output prec_e            s1_mode,
    output logic [A_W-1:0]   opf_a,
    output logic [B_W-1:0]   opf_b,
    output logic [A_W-1:0]   opr_a,
    output logic [RED_W-1:0] opr_b
);
    localparam int unsigned DROP_W = red_shift(B_W, RED_W);

    logic [RED_W-1:0] b_hi;
    assign b_hi = b_in[B_W-1 -: RED_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s1_mode  <= PREC_RED;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_mode <= prec_full ? PREC_FULL : PREC_RED;
            end
        end
    end

    generate
        if (BUILD == BUILD_MASK) begin : g_mask
            logic [B_W-1:0] b_gated;
            always_comb begin
                if (prec_full) b_gated = b_in;
                else           b_gated = {b_hi, {DROP_W{1'b0}}};
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    opf_a <= '0;
                    opf_b <= '0;
                end else if (in_valid) begin
                    opf_a <= a_in;
                    opf_b <= b_gated;
                end
            end

            assign opr_a = '0;
            assign opr_b = '0;
        end else begin : g_split
            always_ff @(posedge clk) begin
                if (rst) begin
                    opf_a <= '0;
                    opf_b <= '0;
                end else if (in_valid && prec_full) begin
                    opf_a <= a_in;
                    opf_b <= b_in;
                end
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    opr_a <= '0;
                    opr_b <= '0;
                end else if (in_valid && !prec_full) begin
                    opr_a <= a_in;
                    opr_b <= b_hi;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/dpmul_full_unit.sv
// Full-width signed array product.
module dpmul_full_unit
    import dpmul_pkg::*;
#(
    parameter int unsigned A_W = DPM_A_W,
    parameter int unsigned B_W = DPM_B_W
) (
    input  logic [A_W-1:0]                    mcand,
    input  logic [B_W-1:0]                    mplier,
    output logic signed [prod_width(A_W, B_W)-1:0] prod
);
    localparam int unsigned P_W = prod_width(A_W, B_W);

    logic signed [P_W-1:0] ax;
    logic signed [P_W-1:0] bx;

    assign ax   = P_W'($signed(mcand));
    assign bx   = P_W'($signed(mplier));
    assign prod = ax * bx;

endmodule

// File: rtl/dpmul_red_unit.sv
// Narrow signed product built from shifted partial terms; the sign bit of
// the short operand carries negative weight. Result is rescaled to the
// full-mode product scale.
module dpmul_red_unit
    import dpmul_pkg::*;
#(
    parameter int unsigned A_W   = DPM_A_W,
    parameter int unsigned B_W   = DPM_B_W,
    parameter int unsigned RED_W = DPM_RED_W
) (
    input  logic [A_W-1:0]                         mcand,
    input  logic [RED_W-1:0]                       mplier,
    output logic signed [prod_width(A_W, B_W)-1:0] prod
);
    localparam int unsigned P_W    = prod_width(A_W, B_W);
    localparam int unsigned DROP_W = red_shift(B_W, RED_W);

    logic signed [P_W-1:0] ax;
    logic signed [P_W-1:0] term [RED_W];
    logic signed [P_W-1:0] acc;

    assign ax = P_W'($signed(mcand));

    generate
        for (genvar i = 0; i < RED_W; i++) begin : g_term
            if (i == RED_W - 1) begin : g_neg
                assign term[i] = mplier[i] ? -(ax <<< i) : '0;
            end else begin : g_pos
                assign term[i] = mplier[i] ? (ax <<< i) : '0;
            end
        end
    endgenerate

    always_comb begin
        acc = '0;
        for (int k = 0; k < RED_W; k++) begin
            acc = acc + term[k];
        end
    end

    assign prod = acc <<< DROP_W;

endmodule

// File: rtl/dpmul_top.sv
module dpmul_top
    import dpmul_pkg::*;
#(
    parameter build_e      BUILD = BUILD_MASK,
    parameter int unsigned A_W   = DPM_A_W,
    parameter int unsigned B_W   = DPM_B_W,
    parameter int unsigned RED_W = DPM_RED_W
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            in_valid,
    input  logic                            prec_full,
    input  logic [A_W-1:0]                  a_in,
    input  logic [B_W-1:0]                  b_in,
    output logic                            out_valid,
    output logic                            out_full,
    output logic [prod_width(A_W, B_W)-1:0] out_prod
);
    localparam int unsigned P_W = prod_width(A_W, B_W);

    logic             s1_valid;
    prec_e            s1_mode;
    logic [A_W-1:0]   opf_a;
    logic [B_W-1:0]   opf_b;
    logic [A_W-1:0]   opr_a;
    logic [RED_W-1:0] opr_b;

    logic signed [P_W-1:0] pf;
    logic [P_W-1:0]        p_sel;

    dpmul_isol #(
        .BUILD (BUILD),
        .A_W   (A_W),
        .B_W   (B_W),
        .RED_W (RED_W)
    ) u_isol (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .prec_full (prec_full),
        .a_in      (a_in),
        .b_in      (b_in),
        .s1_valid  (s1_valid),
        .s1_mode   (s1_mode),
        .opf_a     (opf_a),
        .opf_b     (opf_b),
        .opr_a     (opr_a),
        .opr_b     (opr_b)
    );

    dpmul_full_unit #(
        .A_W (A_W),
        .B_W (B_W)
    ) u_full (
        .mcand  (opf_a),
        .mplier (opf_b),
        .prod   (pf)
    );

    generate
        if (BUILD == BUILD_SPLIT) begin : g_split
            logic signed [P_W-1:0] pr;

            dpmul_red_unit #(
                .A_W   (A_W),
                .B_W   (B_W),
                .RED_W (RED_W)
            ) u_red (
                .mcand  (opr_a),
                .mplier (opr_b),
                .prod   (pr)
            );

            assign p_sel = (s1_mode == PREC_FULL) ? pf : pr;
        end else begin : g_mask
            assign p_sel = pf;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_full  <= 1'b0;
            out_prod  <= '0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) begin
                out_full <= (s1_mode == PREC_FULL);
                out_prod <= p_sel;
            end
        end
    end

endmodule

// File: rtl/dpmul_chk.sv
module dpmul_chk
    import dpmul_pkg::*;
#(
    parameter build_e      BUILD = BUILD_MASK,
    parameter int unsigned A_W   = DPM_A_W,
    parameter int unsigned B_W   = DPM_B_W,
    parameter int unsigned RED_W = DPM_RED_W
) (
    input logic                            clk,
    input logic                            rst,
    input logic                            in_valid,
    input logic                            prec_full,
    input logic                            out_valid,
    input logic                            out_full,
    input logic [prod_width(A_W, B_W)-1:0] out_prod,
    input logic [A_W-1:0]                  opf_a,
    input logic [B_W-1:0]                  opf_b,
    input logic [A_W-1:0]                  opr_a,
    input logic [RED_W-1:0]                opr_b
);
    localparam int unsigned DROP_W = red_shift(B_W, RED_W);

    logic [1:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst)                 since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // R1
    p_reset_clear_r1: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && !out_full && out_prod == '0));

    // R4
    p_valid_latency_r4: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

    // R5
    p_mode_tag_r5: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2 && out_valid) |-> (out_full == $past(prec_full, 2)));

    // R3
    p_red_low_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_full) |-> (out_prod[DROP_W-1:0] == '0));

    // R6
    p_hold_idle_r6: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd1 && !out_valid) |-> ($stable(out_prod) && $stable(out_full)));

    generate
        if (BUILD == BUILD_SPLIT) begin : g_split
            // R3
            p_full_frozen_r3: assert property (@(posedge clk) disable iff (rst)
                (in_valid && !prec_full) |=> ($stable(opf_a) && $stable(opf_b)));
            // R5
            p_red_frozen_r5: assert property (@(posedge clk) disable iff (rst)
                (in_valid && prec_full) |=> ($stable(opr_a) && $stable(opr_b)));
        end
    endgenerate

endmodule

bind dpmul_top dpmul_chk #(
    .BUILD (BUILD),
    .A_W   (A_W),
    .B_W   (B_W),
    .RED_W (RED_W)
) i_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .prec_full (prec_full),
    .out_valid (out_valid),
    .out_full  (out_full),
    .out_prod  (out_prod),
    .opf_a     (opf_a),
    .opf_b     (opf_b),
    .opr_a     (opr_a),
    .opr_b     (opr_b)
);

// File: tb/test_dpmul_top.sv
`timescale 1ns/1ps
module test_dpmul_top;
    import dpmul_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        prec_full = 1'b0;
    logic [15:0] a_in = '0;
    logic [7:0]  b_in = '0;

    logic        m_valid, s_valid;
    logic        m_full,  s_full;
    logic [23:0] m_prod,  s_prod;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    dpmul_top #(.BUILD(BUILD_MASK)) i_dpmul_top (
        .clk(clk), .rst(rst), .in_valid(in_valid), .prec_full(prec_full),
        .a_in(a_in), .b_in(b_in),
        .out_valid(m_valid), .out_full(m_full), .out_prod(m_prod)
    );

    dpmul_top #(.BUILD(BUILD_SPLIT)) i_dpmul_top_split (
        .clk(clk), .rst(rst), .in_valid(in_valid), .prec_full(prec_full),
        .a_in(a_in), .b_in(b_in),
        .out_valid(s_valid), .out_full(s_full), .out_prod(s_prod)
    );

    // Expected pipeline: index 0 = driven last call, 1 = driven two calls ago.
    logic        hv [2];
    logic        hf [2];
    logic [23:0] hp [2];
    logic        last_f;
    logic [23:0] last_p;

    task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h (a=%0h b=%0h)", req, act, exp, a_in, b_in);
        end
    endtask

    function automatic logic [23:0] ref_prod(input logic [15:0] a, input logic [7:0] b, input logic full);
        logic signed [23:0] ax;
        logic signed [23:0] bx;
        ax = 24'($signed(a));
        bx = full ? 24'($signed(b)) : 24'($signed({b[7:4], 4'b0000}));
        return ax * bx;
    endfunction

    function automatic logic [15:0] a_pick(input int i);
        case (i)
            0: return 16'h8000;
            1: return 16'h7FFF;
            2: return 16'h0000;
            3: return 16'hFFFF;
            4: return 16'h0001;
            5: return 16'h5555;
            6: return 16'hAAAA;
            default: return 16'(i * 2111 + 12345);
        endcase
    endfunction

    // Called at a falling edge: check outputs of the pair driven two calls ago, then drive.
    task automatic step(input logic v, input logic f, input logic [15:0] a, input logic [7:0] b);
        logic [23:0] ep;
        logic        ef;
        chk("R4 valid (mask)",  {23'd0, m_valid}, {23'd0, hv[1]});
        chk("R7 valid (split)", {23'd0, s_valid}, {23'd0, hv[1]});
        if (hv[1]) begin
            chk(hf[1] ? "R2 full product (mask)" : "R3 reduced product (mask)", m_prod, hp[1]);
            chk("R5 mode tag (mask)", {23'd0, m_full}, {23'd0, hf[1]});
        end else begin
            chk("R6 held product (mask)", m_prod, hp[1]);
            chk("R6 held mode (mask)", {23'd0, m_full}, {23'd0, hf[1]});
        end
        chk("R7 product match (split)", s_prod, hp[1]);
        chk("R7 mode match (split)", {23'd0, s_full}, {23'd0, hf[1]});
        if (v) begin
            ep = ref_prod(a, b, f);
            ef = f;
            last_p = ep;
            last_f = ef;
        end else begin
            ep = last_p;
            ef = last_f;
        end
        hv[1] = hv[0]; hf[1] = hf[0]; hp[1] = hp[0];
        hv[0] = v;     hf[0] = ef;    hp[0] = ep;
        in_valid  = v;
        prec_full = f;
        a_in      = a;
        b_in      = b;
        @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 2; i++) begin
            hv[i] = 1'b0; hf[i] = 1'b0; hp[i] = '0;
        end
        last_p = '0;
        last_f = 1'b0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset state while held in reset
        chk("R1 out_valid in reset", {23'd0, m_valid}, 24'd0);
        chk("R1 out_prod in reset", m_prod, 24'd0);
        chk("R1 out_full in reset", {23'd0, m_full}, 24'd0);
        chk("R1 split out_prod in reset", s_prod, 24'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 out_valid after reset", {23'd0, m_valid | s_valid}, 24'd0);
        chk("R1 out_prod after reset", m_prod | s_prod, 24'd0);

        // Most negative corners in both modes (R2, R3)
        step(1'b1, 1'b1, 16'h8000, 8'h80);
        step(1'b1, 1'b0, 16'h8000, 8'h80);
        step(1'b1, 1'b1, 16'h8000, 8'h7F);
        step(1'b1, 1'b0, 16'h7FFF, 8'h8F);
        step(1'b0, 1'b1, 16'h1234, 8'h55);
        step(1'b1, 1'b0, 16'h8000, 8'h0F);

        // Sweep: every b for a set of multiplicands, mode flipping on its own pattern
        for (int ai = 0; ai < 24; ai++) begin
            for (int bi = 0; bi < 256; bi++) begin
                step(1'b1, logic'(((bi >> 1) ^ ai) & 1), a_pick(ai), 8'(bi));
                if (bi % 9 == 8) step(1'b0, logic'(bi & 1), 16'hDEAD, 8'hBE);
            end
        end

        // Drain
        step(1'b0, 1'b0, 16'h0, 8'h0);
        step(1'b0, 1'b1, 16'h0, 8'h0);
        step(1'b0, 1'b0, 16'h0, 8'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule